// File: doc/BRIEF.md
# Video Memory Block-Copy DMA Controller

This block copies data from anywhere in a 16-bit address space into an 8 KiB video memory window. The copy always moves whole 16-byte blocks. A processor programs it through five byte-wide registers: two for the source address, two for the destination address, and one control register. A write to the control register sets the transfer length and the mode, and starts the copy. Reading the control register gives the progress of the transfer. The memory side is a single-cycle master. In each copy cycle it asserts a read strobe and a write strobe together, and the byte returned by the read goes straight onto the write data.

There are two modes. In immediate mode the whole transfer runs one byte per clock until it is finished, and `busy` is high the whole time so the processor can be stalled. In blanking mode the engine waits between blocks. Each rising edge of the `hblank` input releases one 16-byte block, and `busy` is high only while that block is being copied. A control write with bit 7 clear, issued while a blanking-mode transfer is pending, cancels that transfer.

The register map is decoded on `reg_addr` as follows: 0 source high, 1 source low, 2 destination high, 3 destination low, 4 control/status. Codes 5 to 7 are unmapped.

Top module: `vram_dma`

## Requirements
- R1: A write to register 1 or 3 stores only data bits 7:4 into address bits 7:4. Address bits 3:0 are always zero, so the first source address that the engine reads is 16-byte aligned.
- R2: A write to register 0 or 2 replaces address bits 15:8 and keeps the stored low byte.
- R3: A start write folds the stored destination into the window: the destination becomes 0x8000 | (destination & 0x1FFF). The first write address of the transfer uses this folded value.
- R4: A start write loads ((data & 0x7F) + 1) × 16 bytes. Immediate mode copies exactly that many bytes, one per clock, starting on the clock after the write.
- R5: Control data bit 7 selects the mode: 0 is immediate mode and 1 is blanking mode. A write with bit 7 clear while no blanking transfer is active starts an immediate transfer.
- R6: A control write with bit 7 clear while a blanking-mode transfer is active sets the remaining count to zero and ends the transfer. No further bytes are copied and no done pulse follows.
- R7: Register 4 reads ((remaining bytes >> 4) − 1) mod 128 in bits 6:0, and the inverse of the active flag in bit 7. Registers 0 to 3 and codes 5 to 7 read 0xFF.
- R8: After reset no copy runs, `busy` and `done` are low, and register 4 reads 0xFF.
- R9: `done` is high for exactly one cycle, on the cycle after the last byte of a transfer is copied.
- R10: In blanking mode, each rising edge of `hblank` while the transfer is active and no block is in flight copies exactly 16 bytes. An edge that arrives during a block is ignored. In immediate mode `hblank` has no effect.
- R11: `busy` is high exactly on copy cycles. On a copy cycle the read and write strobes are high, `mem_wr_data` equals `mem_rd_data`, and both addresses advance by one per copy.
- R12: Writes to registers 0 to 3 while a transfer is active do not change the running transfer. They take effect at the next start.
- R13: The destination address wraps from 0x9FFF to 0x8000 during a copy, and the source address advances without folding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| hblank | input | 1 | Blanking indicator; a rising edge releases one block |
| mem_rd_en | output | 1 | Source read strobe |
| mem_rd_addr | output | 16 | Source byte address |
| mem_rd_data | input | 8 | Source byte, valid in the same cycle |
| mem_wr_en | output | 1 | Destination write strobe |
| mem_wr_addr | output | 16 | Destination byte address |
| mem_wr_data | output | 8 | Destination byte |
| busy | output | 1 | High on each copy cycle |
| done | output | 1 | One-cycle pulse after the final byte |

## Verification
The assertions check the following on every cycle: `done` is a single-cycle pulse and the engine is idle when it fires; the write address stays inside the window; the write address steps by one with a wrap between consecutive copies; unmapped reads return 0xFF; the status register shows the engine as active while a copy runs; and cancellation takes effect on the next cycle. Other behaviour can only be shown by the bench scenarios, which run against a cycle-level reference model. These are the exact block counts for each length code, the alignment of programmed addresses, a transfer held off until an `hblank` edge arrives, edges ignored in the middle of a block, and address registers written mid-transfer that take effect only at the next start.

// File: rtl/vram_dma.sv
module vram_dma #(
  parameter logic [15:0] WIN_BASE = 16'h8000,
  parameter logic [15:0] WIN_MASK = 16'h1FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        hblank,
  output logic        mem_rd_en,
  output logic [15:0] mem_rd_addr,
  input  logic [7:0]  mem_rd_data,
  output logic        mem_wr_en,
  output logic [15:0] mem_wr_addr,
  output logic [7:0]  mem_wr_data,
  output logic        busy,
  output logic        done
);
  localparam int CW = 12;

  logic [15:0]   src_cfg, dst_cfg, src_ptr, dst_ptr;
  logic [CW-1:0] pend;
  logic          hb_mode, active, in_blk, hb_q, done_q;
  logic [3:0]    blk_cnt;
  logic [7:0]    blocks_m1;

  wire ctrl_wr = reg_wr && (reg_addr == 3'd4);
  wire cancel  = ctrl_wr && !reg_wdata[7] && active && hb_mode;
  wire step    = active && (!hb_mode || in_blk);
  wire rise    = hblank && !hb_q;
  wire [15:0] dst_fold = WIN_BASE | (dst_cfg & WIN_MASK);
  wire [15:0] dst_next = WIN_BASE | ((dst_ptr + 16'd1) & WIN_MASK);

  assign blocks_m1   = pend[CW-1:4] - 8'd1;
  assign reg_rdata   = (reg_addr == 3'd4) ? {~active, blocks_m1[6:0]} : 8'hFF;
  assign mem_rd_en   = step;
  assign mem_wr_en   = step;
  assign mem_rd_addr = src_ptr;
  assign mem_wr_addr = dst_ptr;
  assign mem_wr_data = mem_rd_data;
  assign busy        = step;
  assign done        = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_cfg <= '0;
      dst_cfg <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: src_cfg[15:8] <= reg_wdata;
        3'd1: src_cfg[7:0]  <= {reg_wdata[7:4], 4'h0};
        3'd2: dst_cfg[15:8] <= reg_wdata;
        3'd3: dst_cfg[7:0]  <= {reg_wdata[7:4], 4'h0};
        3'd4: if (!cancel) dst_cfg <= dst_fold;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_ptr <= '0;
      dst_ptr <= '0;
      pend    <= '0;
      hb_mode <= 1'b0;
      active  <= 1'b0;
      in_blk  <= 1'b0;
      blk_cnt <= '0;
      hb_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      hb_q   <= hblank;
      done_q <= step && !ctrl_wr && (pend == CW'(1));
      if (ctrl_wr) begin
        in_blk  <= 1'b0;
        blk_cnt <= '0;
        if (cancel) begin
          pend   <= '0;
          active <= 1'b0;
        end else begin
          src_ptr <= src_cfg;
          dst_ptr <= dst_fold;
          pend    <= ({5'd0, reg_wdata[6:0]} + CW'(1)) << 4;
          hb_mode <= reg_wdata[7];
          active  <= 1'b1;
        end
      end else if (step) begin
        src_ptr <= src_ptr + 16'd1;
        dst_ptr <= dst_next;
        pend    <= pend - CW'(1);
        blk_cnt <= blk_cnt + 4'd1;
        if (blk_cnt == 4'hF) in_blk <= 1'b0;
        if (pend == CW'(1)) begin
          active <= 1'b0;
          in_blk <= 1'b0;
        end
      end else if (hb_mode && active && !in_blk && rise) begin
        in_blk  <= 1'b1;
        blk_cnt <= '0;
      end
    end
  end
endmodule

module vram_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  reg_addr,
  input logic        reg_wr,
  input logic [7:0]  reg_wdata,
  input logic [7:0]  reg_rdata,
  input logic        busy,
  input logic        done,
  input logic [15:0] mem_wr_addr,
  input logic        active,
  input logic        hb_mode,
  input logic [11:0] pend
);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && !active));
  // R13
  dst_window_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (mem_wr_addr[15:13] == 3'b100));
  // R7
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n) (reg_addr > 3'd4) |-> (reg_rdata == 8'hFF));
  // R7
  busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n) (busy && reg_addr == 3'd4) |-> !reg_rdata[7]);
  // R6
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd4 && !reg_wdata[7] && active && hb_mode) |=> (!active && pend == 12'd0 && !busy));
  // R11
  consecutive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(reg_wr && reg_addr == 3'd4)) |=>
      (!busy || mem_wr_addr == (16'h8000 | (($past(mem_wr_addr) + 16'd1) & 16'h1FFF))));
endmodule

bind vram_dma vram_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
  .mem_wr_addr(mem_wr_addr), .active(active), .hb_mode(hb_mode), .pend(pend)
);

// File: tb/tb_vram_dma.sv
`timescale 1ns/1ps
module tb_vram_dma;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = 3'd4;
  logic reg_wr = 1'b0, hblank = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata, mem_rd_data, mem_wr_data;
  logic mem_rd_en, mem_wr_en, busy, done;
  logic [15:0] mem_rd_addr, mem_wr_addr;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign mem_rd_data = pat(mem_rd_addr);

  vram_dma dut (.*);

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model
  logic [15:0] m_src_c, m_dst_c, m_src, m_dst;
  int m_pend, m_left;
  bit m_mode, m_act, m_inblk, m_hbp, m_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src_c = 0; m_dst_c = 0; m_src = 0; m_dst = 0; m_pend = 0; m_left = 0;
      m_mode = 0; m_act = 0; m_inblk = 0; m_hbp = 0; m_done = 0;
    end else begin
      bit stp, rs;
      stp = m_act && (!m_mode || m_inblk);
      rs = hblank && !m_hbp;
      m_hbp = hblank;
      m_done = 0;
      if (reg_wr && reg_addr == 0) m_src_c = {reg_wdata, m_src_c[7:0]};
      if (reg_wr && reg_addr == 1) m_src_c = {m_src_c[15:8], reg_wdata & 8'hF0};
      if (reg_wr && reg_addr == 2) m_dst_c = {reg_wdata, m_dst_c[7:0]};
      if (reg_wr && reg_addr == 3) m_dst_c = {m_dst_c[15:8], reg_wdata & 8'hF0};
      if (reg_wr && reg_addr == 4) begin
        m_inblk = 0;
        if (!reg_wdata[7] && m_act && m_mode) begin
          m_pend = 0; m_act = 0;
        end else begin
          m_dst_c = 16'h8000 | (m_dst_c & 16'h1FFF);
          m_src = m_src_c; m_dst = m_dst_c;
          m_pend = (int'(reg_wdata[6:0]) + 1) * 16;
          m_mode = reg_wdata[7]; m_act = 1;
        end
      end else if (stp) begin
        m_src = m_src + 1;
        m_dst = 16'h8000 | ((m_dst + 1) & 16'h1FFF);
        m_pend = m_pend - 1;
        m_left = m_left - 1;
        if (m_left == 0) m_inblk = 0;
        if (m_pend == 0) begin m_act = 0; m_inblk = 0; m_done = 1; end
      end else if (m_mode && m_act && !m_inblk && rs) begin
        m_inblk = 1; m_left = 16;
      end
    end
  end

  int busy_cnt = 0, done_cnt = 0;
  logic [15:0] first_rd, first_wr, rd16, wr16;

  always @(negedge clk) begin
    if (rst_n) begin
      bit eb;
      logic [7:0] er;
      eb = m_act && (!m_mode || m_inblk);
      er = (reg_addr == 4) ? {~m_act, 7'((m_pend / 16 - 1) & 127)} : 8'hFF;
      chk(busy == eb, "R11 busy", busy, eb);
      chk(done == m_done, "R9 done", done, m_done);
      chk(reg_rdata == er, "R7 rdata", reg_rdata, er);
      if (eb) begin
        chk(mem_rd_en && mem_wr_en, "R11 strobes", {mem_rd_en, mem_wr_en}, 3);
        chk(mem_rd_addr == m_src, "R1 rd_addr", mem_rd_addr, m_src);
        chk(mem_wr_addr == m_dst, "R13 wr_addr", mem_wr_addr, m_dst);
        chk(mem_wr_data == pat(m_src), "R11 wr_data", mem_wr_data, pat(m_src));
      end
      if (busy) begin
        if (busy_cnt == 0) begin first_rd = mem_rd_addr; first_wr = mem_wr_addr; end
        if (busy_cnt == 16) begin rd16 = mem_rd_addr; wr16 = mem_wr_addr; end
        busy_cnt++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1 reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); #1 reg_wr = 1'b0; reg_addr = 3'd4;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask
  task automatic clr();
    busy_cnt = 0; done_cnt = 0;
  endtask
  task automatic pulse();
    @(negedge clk); #1 hblank = 1'b1;
    repeat (3) @(negedge clk);
    #1 hblank = 1'b0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(4);
    #1 rst_n = 1'b1;
    idle(2);
    // R8 reset state
    chk(reg_rdata == 8'hFF && !busy && !done, "R8 reset", reg_rdata, 8'hFF);
    reg_addr = 3'd0; #1;
    chk(reg_rdata == 8'hFF, "R7 unmapped src_hi read", reg_rdata, 8'hFF);
    reg_addr = 3'd6; #1;
    chk(reg_rdata == 8'hFF, "R7 unmapped code 6", reg_rdata, 8'hFF);
    reg_addr = 3'd4;

    // R1 R3 R4 R9 immediate two blocks
    wr(0, 8'h12); wr(1, 8'h3F); wr(2, 8'hC1); wr(3, 8'h2F);
    clr(); wr(4, 8'h01);
    idle(40);
    chk(busy_cnt == 32, "R4 byte count", busy_cnt, 32);
    chk(done_cnt == 1, "R9 done count", done_cnt, 1);
    chk(first_rd == 16'h1230, "R1 aligned source", first_rd, 16'h1230);
    chk(first_wr == 16'h8120, "R3 folded destination", first_wr, 16'h8120);
    chk(reg_rdata == 8'hFF, "R7 idle status", reg_rdata, 8'hFF);

    // R2 high byte only, R5 bit7 clear = immediate
    wr(0, 8'h56);
    clr(); wr(4, 8'h00);
    idle(24);
    chk(first_rd == 16'h5630, "R2 high byte replace", first_rd, 16'h5630);
    chk(busy_cnt == 16, "R5 immediate one block", busy_cnt, 16);

    // R13 window wrap
    wr(2, 8'h9F); wr(3, 8'hF7);
    clr(); wr(4, 8'h01);
    idle(40);
    chk(first_wr == 16'h9FF0, "R13 start", first_wr, 16'h9FF0);
    chk(wr16 == 16'h8000, "R13 wrap", wr16, 16'h8000);
    chk(rd16 == 16'h5640, "R13 source no fold", rd16, 16'h5640);

    // R10 blanking mode, three blocks
    clr(); wr(4, 8'h82);
    chk(reg_rdata == 8'h02, "R7 active status", reg_rdata, 8'h02);
    idle(6);
    chk(busy_cnt == 0, "R10 waits for hblank", busy_cnt, 0);
    pulse();
    idle(4);
    pulse();
    idle(25);
    chk(busy_cnt == 16, "R10 one block per edge", busy_cnt, 16);
    chk(reg_rdata == 8'h01, "R7 status after block", reg_rdata, 8'h01);
    wr(0, 8'h77);
    pulse();
    idle(25);
    chk(busy_cnt == 32, "R10 second block", busy_cnt, 32);
    chk(rd16 == 16'h5640, "R12 running transfer unaffected", rd16, 16'h5640);

    // R6 cancel
    wr(4, 8'h00);
    chk(reg_rdata == 8'hFF, "R6 cancel status", reg_rdata, 8'hFF);
    pulse();
    idle(25);
    chk(busy_cnt == 32, "R6 no copy after cancel", busy_cnt, 32);
    chk(done_cnt == 0, "R6 no done on cancel", done_cnt, 0);

    // R12 new source used at next start, R10 hblank ignored in immediate mode
    clr(); wr(4, 8'h00);
    pulse();
    idle(24);
    chk(first_rd == 16'h7730, "R12 next start", first_rd, 16'h7730);
    chk(busy_cnt == 16, "R10 hblank no effect immediate", busy_cnt, 16);
    chk(done_cnt == 1, "R9 done once", done_cnt, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule